// File: doc/BRIEF.md
# Programmable Clock Prescaler

This block divides an oscillator clock by an amount that software sets. The ratio comes from an 8-bit register whose encoding runs backwards. The all-ones value gives the fastest internal clock, which is the oscillator divided by two. Each step down lengthens the divided period by two oscillator cycles, so the all-zeros value gives the oscillator divided by 512. The divided clock appears in two forms. One is a clock-enable pulse that lasts one oscillator cycle per divided period. The other is a toggle output with equal high and low phases, each lasting half the divided period.

A single-bit speed-up control bypasses the divider. While it is set, the enable output is high on every oscillator cycle and the toggle output flips on every cycle. Both the ratio register and the speed-up bit are written through one small write port. A new ratio is held back until the running half-period ends, so no output phase is ever cut short. Oscillator selection happens elsewhere; this block only divides the clock it receives.

Top module: `clk_prescaler`

## Requirements
- R1: Reset loads the ratio register with FFh and clears the speed-up bit. While reset is held, `ck_en` and `ck_tog` are 0. After reset, the divided period is 2 oscillator cycles.
- R2: With the speed-up bit clear and ratio register value C, `ck_en` is high for one cycle every 2 × (256 − C) oscillator cycles.
- R3: C = 00h gives the longest period, 512 cycles. C = FFh gives the shortest, 2 cycles.
- R4: `ck_tog` stays high for (256 − C) cycles and low for (256 − C) cycles. `ck_en` is high exactly in the cycle where `ck_tog` has just gone from 1 to 0.
- R5: A new ratio written part way through a half-period does not change that half-period. The new length applies from the next half-period on.
- R6: While the speed-up bit is 1, `ck_en` is 1 on every cycle and `ck_tog` changes on every cycle.
- R7: A write with `wr_sel` = 0 loads `wr_data` into the ratio register. A write with `wr_sel` = 1 loads `wr_data[0]` into the speed-up bit, and bits 7..1 of that write have no effect.
- R8: The internal phase counter never goes past the limit (255 − C) of the ratio that is currently active.
- R9: While `wr_en` = 0, the values on `wr_sel` and `wr_data` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control port |
| wr_sel | input | 1 | Write target: 0 = ratio register, 1 = speed-up bit |
| wr_data | input | 8 | Write data |
| ck_en | output | 1 | Divided clock-enable pulse |
| ck_tog | output | 1 | Divided toggle clock with equal high and low phases |

## Verification
The assertions assume that `wr_en` is a synchronous strobe lasting one clock cycle and that reset is only released between clock edges. The bench drives every write on a falling edge and holds it for exactly one cycle, and it releases reset away from the rising edge. The pulse-alignment check assumes that the internal toggle phase keeps running while the speed-up bit is set. The bench therefore measures periods only after the speed-up bit has been cleared and several divided periods have passed.

// File: rtl/clk_prescaler_pkg.sv
package clk_prescaler_pkg;
   localparam int unsigned PRE_W = 8;

   typedef enum logic {
      SEL_RATIO = 1'b0,
      SEL_TURBO = 1'b1
   } wr_target_e;

   function automatic logic [PRE_W-1:0] phase_limit(input logic [PRE_W-1:0] ratio);
      return ~ratio;
   endfunction
endpackage

// File: rtl/pdiv_cfg.sv
module pdiv_cfg #(
   parameter int unsigned W           = 8,
   parameter logic [W-1:0] RESET_RATIO = '1,
   parameter bit          HAS_TURBO   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         wrap,
   output logic [W-1:0] ratio_act,
   output logic         turbo
);
   import clk_prescaler_pkg::*;

   logic [W-1:0] ratio_sw;

   initial begin
      assert (W >= 1 && W <= 16) else $error("pdiv_cfg: W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_sw <= RESET_RATIO;
      end else if (wr_en && wr_target_e'(wr_sel) == SEL_RATIO) begin
         ratio_sw <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_act <= RESET_RATIO;
      end else if (wrap) begin
         ratio_act <= ratio_sw;
      end
   end

   generate
      if (HAS_TURBO) begin : g_turbo
         logic turbo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               turbo_q <= 1'b0;
            end else if (wr_en && wr_target_e'(wr_sel) == SEL_TURBO) begin
               turbo_q <= wr_data[0];
            end
         end
         assign turbo = turbo_q;
      end else begin : g_no_turbo
         assign turbo = 1'b0;
      end
   endgenerate

   // R5: the active ratio is only replaced at the end of a half-period
   assert_ratio_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_act != $past(ratio_act)) |-> $past(wrap));

   // R1: reset restores the fastest ratio
   assert_reset_ratio_R1: assert property (@(posedge clk)
      !rst_n |=> (ratio_act == RESET_RATIO) || !rst_n);
endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ratio_act,
   output logic         wrap
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] limit;

   initial begin
      assert (W >= 1) else $error("pdiv_counter: W must be at least 1");
   end

   assign limit = ~ratio_act;
   assign wrap  = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R8: counter stays inside the active half-period
   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit);
endmodule

// File: rtl/pdiv_outputs.sv
module pdiv_outputs (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic turbo,
   output logic ck_en,
   output logic ck_tog
);
   logic tog_q;
   logic en_q;
   logic fast_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         en_q <= wrap & tog_q;
         if (wrap) tog_q <= ~tog_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fast_q <= 1'b0;
      else        fast_q <= ~fast_q;
   end

   assign ck_en  = turbo ? 1'b1   : en_q;
   assign ck_tog = turbo ? fast_q : tog_q;

   // R4: enable pulse lines up with the falling edge of the toggle phase
   assert_pulse_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> ($past(tog_q) && !tog_q));

   // R2: a divided enable pulse never lasts two cycles
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> !en_q);
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
   parameter int unsigned W           = clk_prescaler_pkg::PRE_W,
   parameter logic [W-1:0] RESET_RATIO = '1,
   parameter bit          HAS_TURBO   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   output logic         ck_en,
   output logic         ck_tog
);
   logic [W-1:0] ratio_act;
   logic         turbo;
   logic         wrap;

   pdiv_cfg #(.W(W), .RESET_RATIO(RESET_RATIO), .HAS_TURBO(HAS_TURBO)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .wrap      (wrap),
      .ratio_act (ratio_act),
      .turbo     (turbo)
   );

   pdiv_counter #(.W(W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_act (ratio_act),
      .wrap      (wrap)
   );

   pdiv_outputs u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (wrap),
      .turbo  (turbo),
      .ck_en  (ck_en),
      .ck_tog (ck_tog)
   );

   // R6: bypass holds the enable high
   assert_turbo_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      turbo |-> ck_en);

   // R6: bypass toggles every cycle
   assert_turbo_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (turbo && $past(turbo)) |-> (ck_tog != $past(ck_tog)));

   // R1: outputs quiet under reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!ck_en && !ck_tog));
endmodule

// File: tb/sim_clk_prescaler.sv
module sim_clk_prescaler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       ck_en;
   logic       ck_tog;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clk_prescaler u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ck_en(ck_en), .ck_tog(ck_tog)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00; wr_sel = 1'b0;
   endtask

   task automatic wait_en();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (ck_en) return;
      end
   endtask

   task automatic period(output int p);
      wait_en();
      p = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         p++;
         if (ck_en) return;
      end
   endtask

   task automatic high_len(output int h);
      h = 0;
      for (int i = 0; i < 2000 && ck_tog; i++) @(negedge clk);
      for (int i = 0; i < 2000 && !ck_tog; i++) @(negedge clk);
      for (int i = 0; i < 2000 && ck_tog; i++) begin
         h++;
         @(negedge clk);
      end
   endtask

   task automatic check_ratio(input logic [7:0] c, input string req);
      int p, h, n;
      n = 256 - int'(c);
      write_reg(1'b0, c);
      for (int k = 0; k < 3; k++) wait_en();
      period(p);
      check(p == 2 * n, req, p, 2 * n);
      high_len(h);
      check(h == n, "R4 high phase", h, n);
   endtask

   task automatic t_reset();
      int p;
      @(negedge clk);
      check(ck_en == 1'b0 && ck_tog == 1'b0, "R1 outputs in reset", {ck_en, ck_tog}, 0);
      rst_n = 1'b1;
      period(p);
      check(p == 2, "R1 period after reset", p, 2);
   endtask

   task automatic t_ratios();
      check_ratio(8'h00, "R3 slowest ratio");
      check_ratio(8'hFF, "R3 fastest ratio");
      check_ratio(8'h80, "R2 ratio 80h");
      check_ratio(8'hFE, "R2 ratio FEh");
      check_ratio(8'h7F, "R2 ratio 7Fh");
   endtask

   task automatic t_align();
      int bad = 0;
      logic prev_tog;
      write_reg(1'b0, 8'hFA);
      for (int k = 0; k < 3; k++) wait_en();
      prev_tog = ck_tog;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (ck_en != (prev_tog && !ck_tog)) bad++;
         prev_tog = ck_tog;
      end
      check(bad == 0, "R4 pulse on falling toggle", bad, 0);
   endtask

   task automatic t_midphase();
      int low_n, h;
      write_reg(1'b0, 8'hF0);
      for (int k = 0; k < 3; k++) wait_en();
      for (int i = 0; i < 100 && !ck_tog; i++) @(negedge clk);
      for (int i = 0; i < 100 && ck_tog; i++) @(negedge clk);
      low_n = 0;
      for (int i = 0; i < 5; i++) begin
         low_n++;
         @(negedge clk);
      end
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFC;
      low_n++;
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < 100 && !ck_tog; i++) begin
         low_n++;
         @(negedge clk);
      end
      check(low_n == 16, "R5 phase in progress keeps old length", low_n, 16);
      h = 0;
      for (int i = 0; i < 100 && ck_tog; i++) begin
         h++;
         @(negedge clk);
      end
      check(h == 4, "R5 next phase uses new length", h, 4);
   endtask

   task automatic t_no_write();
      int p;
      write_reg(1'b0, 8'hFD);
      for (int k = 0; k < 3; k++) wait_en();
      @(negedge clk);
      wr_sel = 1'b0; wr_data = 8'h10;
      repeat (4) @(negedge clk);
      wr_sel = 1'b1; wr_data = 8'hFF;
      repeat (4) @(negedge clk);
      wr_sel = 1'b0; wr_data = 8'h00;
      period(p);
      check(p == 6, "R9 idle port keeps ratio", p, 6);
      check(ck_en == 1'b1, "R9 idle port keeps speed-up off", ck_en, 1);
      @(negedge clk);
      check(ck_en == 1'b0, "R9 enable not held high", ck_en, 0);
   endtask

   task automatic t_turbo();
      int bad = 0;
      int p;
      logic prev;
      write_reg(1'b1, 8'h01);
      prev = ck_tog;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (!ck_en || ck_tog == prev) bad++;
         prev = ck_tog;
      end
      check(bad == 0, "R6 bypass every cycle", bad, 0);
      write_reg(1'b1, 8'hFE);
      period(p);
      check(p == 6, "R7 speed-up cleared by bit 0", p, 6);
      write_reg(1'b1, 8'h02);
      period(p);
      check(p == 6, "R7 upper data bits ignored", p, 6);
   endtask

   task automatic t_reset_again();
      int p;
      write_reg(1'b0, 8'h20);
      write_reg(1'b1, 8'h01);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(ck_en == 1'b0 && ck_tog == 1'b0, "R1 outputs under reset", {ck_en, ck_tog}, 0);
      rst_n = 1'b1;
      period(p);
      check(p == 2, "R1 reset restores ratio and clears speed-up", p, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_ratios();
      t_align();
      t_midphase();
      t_no_write();
      t_turbo();
      t_reset_again();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule